// File: doc/BRIEF.md
# Event-Latched Status Register Bank with Interrupt Pin

This block collects single-cycle hardware event pulses into sticky status bits, grouped into banks of equal width. A bit stays set once its event fires and is cleared only when the host reads the bank that holds it. The read is collision-safe. The value returned is the bank as it stood in the strobe cycle. Only the bits returned as 1 are cleared. An event pulse that arrives in the strobe cycle is not in the returned value and is still latched after the read.

Each bank has a companion enable register that the host can write and read back. The interrupt output is active-low. It is asserted whenever any status bit is set together with its enable. A configuration bit selects what the pin does while it is inactive. When the bit is set, the pin drives high. When the bit is clear, the pin floats.

The pad itself is outside the block. The block drives it through a level signal and an output-enable signal. Host bus decoding is also outside the block. The block takes a one-cycle read strobe with an address, and a one-cycle write strobe with an address and data. These are plain control pins, so there is no back-pressure.

Top module: `latched_status_irq`

## Requirements
- R1: After reset, every status bit, every enable bit and the drive-high bit read as 0, and the interrupt pad is not enabled (`irq_oe`=0).
- R2: A pulse on an event input sets its status bit at the next clock edge, and further pulses leave it set.
- R3: A read strobe returns the addressed register, as it stood in the strobe cycle, on `rd_data` in the following cycle with `rd_valid` high for that one cycle. `rd_data` holds its value between reads.
- R4: A read of status bank k clears exactly the bits it returned as 1 and leaves every other bank unchanged.
- R5: An event pulse in the same cycle as a read of its bank is absent from that read value and stays latched afterwards.
- R6: The enable registers and the drive-high bit are written by the write strobe and read back unchanged, and reading them clears nothing.
- R7: While any status bit and its enable are both 1, `irq_n`=0 and `irq_oe`=1.
- R8: While no enabled status bit is set, `irq_oe` equals the drive-high bit and `irq_n`=1.
- R9: Addresses 0..N-1 select status banks, N..2N-1 select enable banks, and 2N selects the drive-high bit at data bit 0. Any other address reads 0. Writes to status addresses or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | N*W | Event pulses, bank k in bits [k*W +: W] |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | W | Read data |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| irq_n | output | 1 | Interrupt level to the pad, active low |
| irq_oe | output | 1 | Pad output enable; 0 leaves the pin floating |

## Verification
The bench builds the block with three banks of five bits. This is an odd width, and it gives seven mapped addresses in a three-bit address space. Address 7 therefore gives the bench an unmapped location to read and write. Having three banks also lets the bench check that a clearing read of one bank leaves its neighbours untouched. Random traffic often places event pulses in the same cycle as reads and enable writes. Each such collision is compared against the reference model on every clock.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CFG    = 2'd2,
    SEL_NONE   = 2'd3
  } sel_kind_e;

  function automatic sel_kind_e classify(input int unsigned addr, input int unsigned nbank);
    if (addr < nbank)          return SEL_STATUS;
    else if (addr < 2 * nbank) return SEL_ENABLE;
    else if (addr == 2 * nbank) return SEL_CFG;
    else                       return SEL_NONE;
  endfunction
endpackage

// File: rtl/lsi_bank.sv
module lsi_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] st_o,
  output logic [W-1:0] en_o
);
  logic [W-1:0] st_q, en_q, clr_mask;

  // Clear only what the read returns; new events win over the clear.
  assign clr_mask = rd_clr ? st_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_mask) | evt;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((st_q & $past(st_q)) == $past(st_q)));
  p_evt_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(evt)) == $past(evt)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((st_q & $past(st_q) & ~$past(evt)) == '0));
endmodule

// File: rtl/lsi_irq_pad.sv
module lsi_irq_pad #(
  parameter int N = 2,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] st_flat,
  input  logic [N*W-1:0] en_flat,
  input  logic           drive_hi,
  output logic           irq_n,
  output logic           irq_oe
);
  logic [N-1:0] bank_hit;

  for (genvar b = 0; b < N; b++) begin : g_hit
    assign bank_hit[b] = |(st_flat[b*W +: W] & en_flat[b*W +: W]);
  end

  logic active;
  assign active = |bank_hit;
  assign irq_n  = !active;
  assign irq_oe = active | drive_hi;

  p_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !drive_hi) |-> !irq_oe);
endmodule

// File: rtl/latched_status_irq.sv
module latched_status_irq
  import lsi_pkg::*;
#(
  parameter int N  = 2,
  parameter int W  = 8,
  parameter int AW = $clog2(2 * N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] evt,
  input  logic           rd_stb,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_valid,
  output logic [W-1:0]   rd_data,
  input  logic           wr_stb,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic           irq_n,
  output logic           irq_oe
);
  localparam int CFG_ADDR = 2 * N;

  logic [N*W-1:0] st_flat, en_flat;
  logic           drive_hi_q;
  sel_kind_e      rd_kind, wr_kind;

  assign rd_kind = classify(int'(rd_addr), N);
  assign wr_kind = classify(int'(wr_addr), N);

  for (genvar b = 0; b < N; b++) begin : g_bank
    logic rclr, ewe;
    assign rclr = rd_stb && (rd_kind == SEL_STATUS) && (int'(rd_addr) == b);
    assign ewe  = wr_stb && (wr_kind == SEL_ENABLE) && (int'(wr_addr) == N + b);
    lsi_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt[b*W +: W]),
      .rd_clr   (rclr),
      .en_we    (ewe),
      .en_wdata (wr_data),
      .st_o     (st_flat[b*W +: W]),
      .en_o     (en_flat[b*W +: W])
    );
  end

  // Read mux.
  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (rd_kind)
      SEL_STATUS: for (int b = 0; b < N; b++)
                    if (int'(rd_addr) == b) rd_mux = st_flat[b*W +: W];
      SEL_ENABLE: for (int b = 0; b < N; b++)
                    if (int'(rd_addr) == N + b) rd_mux = en_flat[b*W +: W];
      SEL_CFG:    rd_mux = W'(drive_hi_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      drive_hi_q <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= rd_mux;
      if (wr_stb && wr_kind == SEL_CFG) drive_hi_q <= wr_data[0];
    end
  end

  lsi_irq_pad #(.N(N), .W(W)) u_pad (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_flat  (st_flat),
    .en_flat  (en_flat),
    .drive_hi (drive_hi_q),
    .irq_n    (irq_n),
    .irq_oe   (irq_oe)
  );

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_flat & en_flat) != '0) |-> (!irq_n && irq_oe));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_flat & en_flat) == '0) |-> (irq_n && (irq_oe == drive_hi_q)));
  p_status_noclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_kind != SEL_STATUS) |=> ((st_flat & $past(st_flat)) == $past(st_flat)));
endmodule

// File: tb/sim_latched_status_irq.sv
module sim_latched_status_irq;
  localparam int N  = 3;
  localparam int W  = 5;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W-1:0] evt = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid, irq_n, irq_oe;
  logic [W-1:0] rd_data;

  always #10 clk = ~clk;

  latched_status_irq #(.N(N), .W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  int m_st[N], m_en[N], m_cfg, m_rdv, m_rdd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < N; b++) begin m_st[b] = 0; m_en[b] = 0; end
      m_cfg = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      int a, rv;
      a = int'(rd_addr);
      rv = 0;
      if (a < N) rv = m_st[a];
      else if (a < 2*N) rv = m_en[a-N];
      else if (a == 2*N) rv = m_cfg;
      m_rdv = rd_stb ? 1 : 0;
      if (rd_stb) m_rdd = rv;
      for (int b = 0; b < N; b++) begin
        if (rd_stb && a == b) m_st[b] = 0;
        m_st[b] = m_st[b] | int'(evt[b*W +: W]);
      end
      if (wr_stb) begin
        int wa;
        wa = int'(wr_addr);
        if (wa >= N && wa < 2*N) m_en[wa-N] = int'(wr_data);
        else if (wa == 2*N) m_cfg = int'(wr_data[0]);
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    int any;
    any = 0;
    for (int b = 0; b < N; b++) if ((m_st[b] & m_en[b]) != 0) any = 1;
    chk("R3 rd_valid", int'(rd_valid), m_rdv);
    chk("R3 rd_data", int'(rd_data), m_rdd);
    chk("R7 irq_n", int'(irq_n), any ? 0 : 1);
    chk("R8 irq_oe", int'(irq_oe), (any != 0 || m_cfg != 0) ? 1 : 0);
  end

  task automatic rd_evt(input int a, input int ev, output int d);
    @(posedge clk); #5;
    rd_stb = 1'b1; rd_addr = AW'(a); evt = (N*W)'(ev);
    @(posedge clk); #5;
    rd_stb = 1'b0; evt = '0;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic do_read(input int a, output int d);
    rd_evt(a, 0, d);
  endtask

  task automatic pulse(input int ev);
    @(posedge clk); #5; evt = (N*W)'(ev);
    @(posedge clk); #5; evt = '0;
  endtask

  task automatic do_write(input int a, input int v);
    @(posedge clk); #5; wr_stb = 1'b1; wr_addr = AW'(a); wr_data = W'(v);
    @(posedge clk); #5; wr_stb = 1'b0;
  endtask

  bit done = 0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_oe after reset", int'(irq_oe), 0);
    for (int a = 0; a <= 2*N; a++) begin
      do_read(a, d); chk("R1 reset value", d, 0);
    end
    // R2: sticky set
    pulse(32'h2); pulse(32'h2);
    do_read(0, d); chk("R2 sticky bit", d, 2);
    do_read(0, d); chk("R4 cleared after read", d, 0);
    // R4: clear one bank only
    pulse(32'h9 | (32'h4 << W));
    do_read(0, d); chk("R4 bank0 value", d, 9);
    do_read(1, d); chk("R4 bank1 untouched", d, 4);
    // R5: collision
    pulse(32'h1 << (2*W));
    rd_evt(2, 32'h10 << (2*W), d); chk("R5 read excludes new event", d, 1);
    do_read(2, d); chk("R5 new event kept", d, 16);
    // R6: enable register
    pulse(32'h1 << W);
    do_write(N+1, 5);
    do_read(N+1, d); chk("R6 enable readback", d, 5);
    @(negedge clk);
    chk("R7 irq_n asserted", int'(irq_n), 0);
    chk("R7 irq_oe asserted", int'(irq_oe), 1);
    do_read(1, d); chk("R6 status survives enable read", d, 1);
    @(negedge clk);
    chk("R8 released floats", int'(irq_oe), 0);
    do_write(2*N, 1);
    @(negedge clk);
    chk("R8 drive high oe", int'(irq_oe), 1);
    chk("R8 drive high level", int'(irq_n), 1);
    do_read(2*N, d); chk("R6 cfg readback", d, 1);
    // R9: map
    do_read(7, d); chk("R9 unmapped reads 0", d, 0);
    do_write(0, 31); do_write(7, 31);
    do_read(0, d); chk("R9 status write ignored", d, 0);
    do_read(N, d); chk("R9 enable0 unchanged", d, 0);
    // Random traffic, compared by the model each clock.
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #5;
      evt     = (($urandom % 4) == 0) ? (N*W)'($urandom) : '0;
      rd_stb  = ($urandom % 3) == 0;
      rd_addr = AW'($urandom);
      wr_stb  = ($urandom % 5) == 0;
      wr_addr = AW'($urandom);
      wr_data = W'($urandom);
    end
    @(posedge clk); #5;
    evt = '0; rd_stb = 1'b0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule